// File: doc/BRIEF.md
# Key-Locked Configuration Index/Data Port

This block is the configuration window of a multi-function peripheral controller. A host reaches it through two byte-wide addresses on a simple synchronous bus: offset 0 is the index port and offset 1 is the data port. The window comes up locked. The host opens it by writing the unlock key to the index port on two index writes in a row, and closes it again by writing the lock key to the index port. The unlock key defaults to 0x87 and the lock key to 0xAA. Both keys are parameters, so a part that uses the pair 0x88/0xBB is built from the same code.

While the window is open, an index-port write latches a register number. Each later data-port read or write then goes to that register. One global register selects the logical device whose registers appear behind the window. A second global register returns a fixed chip identification byte. For the one logical device that this block serves, the block holds the activate bit itself. It passes every higher register number of that device through to the device's own register logic over a strobe interface.

Top module: `cfgport_top`

## Requirements
- R1: After reset the window is locked, the latched index is 0x00, the logical-device select is 0x00, and `dev_active` is 0.
- R2: The window opens only after the unlock key is written to the index port on two consecutive index-port writes. After only one key write, data reads still return 0xFF.
- R3: Between the first and second unlock key, an index-port write of any other value cancels the sequence. Two further key writes are then needed to open the window.
- R4: While the window is open, an index-port write of the lock key closes it. The lock key is not latched as an index.
- R5: While the window is locked, data-port writes change no register, and reads of either port return 0xFF.
- R6: While the window is open, an index-port write latches the index. All following data accesses target that index until the index port is written again. Locking and reopening leave the latched index unchanged.
- R7: Register 0x07 is the logical-device select. It is read/write, and its value appears on `dev_ldn`.
- R8: Register 0x20 always reads the CHIP_ID parameter (default 0xC7). Writes to it are ignored.
- R9: Register 0x30 is the activate register when the select equals DEV_LDN (default 0x08). Bit 0 is the activate bit, drives `dev_active`, and bits 7:1 read 0. When any other device is selected, index 0x30 reads 0xFF and writes to it are ignored.
- R10: When the select equals DEV_LDN, an open-window data access at an index above 0x30 is passed to the device. A write pulses `dev_wr` with `dev_idx` and `dev_wdata`. A read pulses `dev_rd` and returns `dev_rdata`. When any other device is selected, neither strobe asserts.
- R11: While the window is open, an index-port read returns the latched index. A data read of an index that is not mapped returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 1 | 0 selects the index port, 1 selects the data port |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the current state |
| dev_ldn | output | 8 | Current logical-device select |
| dev_active | output | 1 | Activate bit of the served device |
| dev_wr | output | 1 | Pass-through write strobe |
| dev_rd | output | 1 | Pass-through read strobe |
| dev_idx | output | 8 | Pass-through register index |
| dev_wdata | output | 8 | Pass-through write data |
| dev_rdata | input | 8 | Read data returned by the device registers |

## Verification
A key sequencer stuck in its half-open state, or one that rearms on the wrong write, shows as soon as the next data-port read. That read returns 0xFF where a register value is expected, or a value where 0xFF is expected. A latched index that drifts, or that is overwritten by the lock key, returns the wrong register on the first data read after the event. A logical-device select that decodes wrongly shows as an activate bit that the next read does not return, or as a stray `dev_wr` or `dev_rd` strobe in the same cycle as the access.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

  typedef enum logic [1:0] {
    KEY_LOCKED = 2'd0,
    KEY_HALF   = 2'd1,
    KEY_OPEN   = 2'd2
  } key_state_e;

  localparam logic       PORT_INDEX = 1'b0;
  localparam logic       PORT_DATA  = 1'b1;

  localparam logic [7:0] IDX_LDN_SEL = 8'h07;
  localparam logic [7:0] IDX_CHIP_ID = 8'h20;
  localparam logic [7:0] IDX_ACTIVE  = 8'h30;

  localparam logic [7:0] BYTE_ABSENT = 8'hFF;

endpackage

// File: rtl/cfg_key_fsm.sv
module cfg_key_fsm
  import cfgport_pkg::*;
#(
  parameter logic [7:0] UNLOCK_KEY = 8'h87,
  parameter logic [7:0] LOCK_KEY   = 8'hAA
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  output logic       cfg_open,
  output logic       idx_load
);

  key_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (idx_wr) begin
      unique case (state_q)
        KEY_LOCKED: state_d = (wdata == UNLOCK_KEY) ? KEY_HALF : KEY_LOCKED;
        KEY_HALF:   state_d = (wdata == UNLOCK_KEY) ? KEY_OPEN : KEY_LOCKED;
        KEY_OPEN:   state_d = (wdata == LOCK_KEY)   ? KEY_LOCKED : KEY_OPEN;
        default:    state_d = KEY_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= KEY_LOCKED;
    else        state_q <= state_d;
  end

  assign cfg_open = (state_q == KEY_OPEN);
  assign idx_load = cfg_open && idx_wr && (wdata != LOCK_KEY);

  // R2: the window opens only out of the half-open state
  p_open_from_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_open) |-> ($past(state_q) == KEY_HALF));

  // R3: a wrong key between the two unlock writes rearms the sequence
  p_rearm_on_bad_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == KEY_HALF && idx_wr && wdata != UNLOCK_KEY) |=> (state_q == KEY_LOCKED));

  // R4: the lock key closes an open window
  p_lock_key_closes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && idx_wr && wdata == LOCK_KEY) |=> !cfg_open);

endmodule

// File: rtl/cfg_reg_file.sv
module cfg_reg_file
  import cfgport_pkg::*;
#(
  parameter logic [7:0] CHIP_ID = 8'hC7,
  parameter logic [7:0] DEV_LDN = 8'h08
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_open,
  input  logic       idx_load,
  input  logic       data_wr,
  input  logic [7:0] wdata,
  output logic [7:0] index_q,
  output logic [7:0] ldn_q,
  output logic       act_q,
  output logic       reg_hit,
  output logic [7:0] reg_rdata
);

  logic [7:0] index_d, ldn_d;
  logic       act_d;
  logic       dev_sel;
  logic       wr_en;

  assign dev_sel = (ldn_q == DEV_LDN);
  assign wr_en   = cfg_open && data_wr;

  always_comb begin
    index_d = index_q;
    ldn_d   = ldn_q;
    act_d   = act_q;
    if (idx_load) index_d = wdata;
    if (wr_en && index_q == IDX_LDN_SEL) ldn_d = wdata;
    if (wr_en && dev_sel && index_q == IDX_ACTIVE) act_d = wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      index_q <= 8'h00;
      ldn_q   <= 8'h00;
      act_q   <= 1'b0;
    end else begin
      index_q <= index_d;
      ldn_q   <= ldn_d;
      act_q   <= act_d;
    end
  end

  always_comb begin
    reg_hit   = 1'b1;
    reg_rdata = BYTE_ABSENT;
    if (index_q == IDX_LDN_SEL)                reg_rdata = ldn_q;
    else if (index_q == IDX_CHIP_ID)           reg_rdata = CHIP_ID;
    else if (index_q == IDX_ACTIVE && dev_sel) reg_rdata = {7'b0, act_q};
    else                                       reg_hit   = 1'b0;
  end

  // R5: a locked window holds the select and the activate bit
  p_locked_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |=> ($stable(ldn_q) && $stable(act_q)));

  // R6: the index changes only on an open-window index write
  p_index_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_load |=> $stable(index_q));

  // R8: the chip identification register is constant
  p_chip_id_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (index_q == IDX_CHIP_ID) |-> (reg_rdata == CHIP_ID));

  // R9: the activate bit moves only while its device is selected
  p_act_needs_dev_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_q) |-> ($past(ldn_q) == DEV_LDN));

endmodule

// File: rtl/cfg_dev_bridge.sv
module cfg_dev_bridge
  import cfgport_pkg::*;
#(
  parameter logic [7:0] DEV_LDN = 8'h08
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_open,
  input  logic       data_wr,
  input  logic       data_rd,
  input  logic [7:0] index_q,
  input  logic [7:0] ldn_q,
  input  logic [7:0] wdata,
  output logic       pass_sel,
  output logic       dev_wr,
  output logic       dev_rd,
  output logic [7:0] dev_idx,
  output logic [7:0] dev_wdata
);

  assign pass_sel  = (ldn_q == DEV_LDN) && (index_q > IDX_ACTIVE);
  assign dev_wr    = cfg_open && pass_sel && data_wr;
  assign dev_rd    = cfg_open && pass_sel && data_rd;
  assign dev_idx   = index_q;
  assign dev_wdata = wdata;

  // R10: a device strobe never fires while the window is locked
  p_strobe_needs_open_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_wr || dev_rd) |-> (cfg_open && ldn_q == DEV_LDN));

  // R10: only one strobe at a time
  p_single_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dev_wr, dev_rd}));

endmodule

// File: rtl/cfgport_top.sv
module cfgport_top
  import cfgport_pkg::*;
#(
  parameter logic [7:0] UNLOCK_KEY = 8'h87,
  parameter logic [7:0] LOCK_KEY   = 8'hAA,
  parameter logic [7:0] CHIP_ID    = 8'hC7,
  parameter logic [7:0] DEV_LDN    = 8'h08
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic [7:0] dev_ldn,
  output logic       dev_active,
  output logic       dev_wr,
  output logic       dev_rd,
  output logic [7:0] dev_idx,
  output logic [7:0] dev_wdata,
  input  logic [7:0] dev_rdata
);

  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  logic       idx_wr, data_wr, data_rd;
  logic       cfg_open, idx_load;
  logic [7:0] index_q, ldn_q;
  logic       act_q, reg_hit, pass_sel;
  logic [7:0] reg_rdata;

  assign idx_wr  = bus_wr && (bus_addr == PORT_INDEX);
  assign data_wr = bus_wr && (bus_addr == PORT_DATA);
  assign data_rd = bus_rd && (bus_addr == PORT_DATA);

  cfg_key_fsm #(
    .UNLOCK_KEY(UNLOCK_KEY),
    .LOCK_KEY  (LOCK_KEY)
  ) u_key (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .idx_wr  (idx_wr),
    .wdata   (bus_wdata),
    .cfg_open(cfg_open),
    .idx_load(idx_load)
  );

  cfg_reg_file #(
    .CHIP_ID(CHIP_ID),
    .DEV_LDN(DEV_LDN)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .cfg_open (cfg_open),
    .idx_load (idx_load),
    .data_wr  (data_wr),
    .wdata    (bus_wdata),
    .index_q  (index_q),
    .ldn_q    (ldn_q),
    .act_q    (act_q),
    .reg_hit  (reg_hit),
    .reg_rdata(reg_rdata)
  );

  cfg_dev_bridge #(
    .DEV_LDN(DEV_LDN)
  ) u_bridge (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .cfg_open (cfg_open),
    .data_wr  (data_wr),
    .data_rd  (data_rd),
    .index_q  (index_q),
    .ldn_q    (ldn_q),
    .wdata    (bus_wdata),
    .pass_sel (pass_sel),
    .dev_wr   (dev_wr),
    .dev_rd   (dev_rd),
    .dev_idx  (dev_idx),
    .dev_wdata(dev_wdata)
  );

  always_comb begin
    bus_rdata = BYTE_ABSENT;
    if (cfg_open) begin
      if (bus_addr == PORT_INDEX) bus_rdata = index_q;
      else if (reg_hit)           bus_rdata = reg_rdata;
      else if (pass_sel)          bus_rdata = dev_rdata;
    end
  end

  assign dev_ldn    = ldn_q;
  assign dev_active = act_q;

  // R5: a locked window reads as an absent device on both ports
  p_locked_reads_ff_r5: assert property (@(posedge clk) disable iff (!rst_n_i)
    (!cfg_open && bus_rd) |-> (bus_rdata == BYTE_ABSENT));

endmodule

// File: tb/cfgport_top_bench.sv
module cfgport_top_bench;

  localparam logic [1:0] OP_IW = 2'd0;
  localparam logic [1:0] OP_DW = 2'd1;
  localparam logic [1:0] OP_DR = 2'd2;
  localparam logic [1:0] OP_IR = 2'd3;
  localparam int NVEC = 30;

  // {op, data, expected, requirement number for the message}
  localparam logic [21:0] VEC [0:NVEC-1] = '{
    {OP_DR, 8'h00, 8'hFF, 4'd5},  // R5 locked read of data port
    {OP_DW, 8'h33, 8'h00, 4'd5},  // R5 locked write ignored
    {OP_IW, 8'h87, 8'h00, 4'd2},  // first key
    {OP_IW, 8'h12, 8'h00, 4'd3},  // R3 wrong byte cancels
    {OP_IW, 8'h87, 8'h00, 4'd3},  // key again
    {OP_DR, 8'h00, 8'hFF, 4'd3},  // R3 still locked after one fresh key
    {OP_IW, 8'h87, 8'h00, 4'd2},  // R2 second consecutive key opens
    {OP_IW, 8'h07, 8'h00, 4'd7},
    {OP_DR, 8'h00, 8'h00, 4'd1},  // R1 select resets to 0
    {OP_IR, 8'h00, 8'h07, 4'd11}, // R11 index readback
    {OP_IW, 8'h20, 8'h00, 4'd8},
    {OP_DR, 8'h00, 8'hC7, 4'd8},  // R8 chip id
    {OP_DW, 8'h00, 8'h00, 4'd8},  // R8 write ignored
    {OP_DR, 8'h00, 8'hC7, 4'd6},  // R6 same index reused
    {OP_IW, 8'h30, 8'h00, 4'd9},
    {OP_DR, 8'h00, 8'hFF, 4'd9},  // R9 other device selected
    {OP_IW, 8'h07, 8'h00, 4'd7},
    {OP_DW, 8'h08, 8'h00, 4'd7},
    {OP_DR, 8'h00, 8'h08, 4'd7},  // R7 select readback
    {OP_IW, 8'h30, 8'h00, 4'd9},
    {OP_DR, 8'h00, 8'h00, 4'd9},  // R9 activate clear
    {OP_DW, 8'hFF, 8'h00, 4'd9},
    {OP_DR, 8'h00, 8'h01, 4'd9},  // R9 only bit 0 stored
    {OP_IW, 8'hAA, 8'h00, 4'd4},  // lock
    {OP_DR, 8'h00, 8'hFF, 4'd4},  // R4 locked again
    {OP_IR, 8'h00, 8'hFF, 4'd5},  // R5 index port locked
    {OP_DW, 8'h00, 8'h00, 4'd5},  // R5 locked write to activate
    {OP_IW, 8'h87, 8'h00, 4'd2},
    {OP_IW, 8'h87, 8'h00, 4'd2},
    {OP_DR, 8'h00, 8'h01, 4'd6}   // R6 index 0x30 kept, R5 write ignored
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_addr = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [7:0] dev_ldn;
  logic       dev_active;
  logic       dev_wr;
  logic       dev_rd;
  logic [7:0] dev_idx;
  logic [7:0] dev_wdata;
  logic [7:0] dev_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] s_rdata;
  logic       s_dwr, s_drd;
  logic [7:0] s_didx, s_dwdata;

  always #5 clk = ~clk;

  assign dev_rdata = dev_idx ^ 8'h3C;

  cfgport_top u_cfgport_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .dev_ldn   (dev_ldn),
    .dev_active(dev_active),
    .dev_wr    (dev_wr),
    .dev_rd    (dev_rd),
    .dev_idx   (dev_idx),
    .dev_wdata (dev_wdata),
    .dev_rdata (dev_rdata)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_op(input logic [1:0] op, input logic [7:0] d);
    @(negedge clk);
    bus_addr  = (op == OP_DW || op == OP_DR);
    bus_wr    = (op == OP_IW || op == OP_DW);
    bus_rd    = (op == OP_DR || op == OP_IR);
    bus_wdata = d;
    #2;
    s_rdata  = bus_rdata;
    s_dwr    = dev_wr;
    s_drd    = dev_rd;
    s_didx   = dev_idx;
    s_dwdata = dev_wdata;
    @(posedge clk);
    #1;
    bus_wr = 1'b0;
    bus_rd = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    do_reset();
    // R1: reset state at the ports
    #2;
    check("R1 dev_active", {7'b0, dev_active}, 8'h00);
    check("R1 dev_ldn", dev_ldn, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      bus_op(VEC[i][21:20], VEC[i][19:12]);
      if (VEC[i][21:20] == OP_DR || VEC[i][21:20] == OP_IR)
        check($sformatf("R%0d vec %0d", VEC[i][3:0], i), s_rdata, VEC[i][11:4]);
    end

    // R9: activate bit visible on dev_active
    #2;
    check("R9 dev_active", {7'b0, dev_active}, 8'h01);
    // R7: select on dev_ldn
    check("R7 dev_ldn", dev_ldn, 8'h08);

    // R10: pass-through write and read
    bus_op(OP_IW, 8'h31);
    bus_op(OP_DW, 8'h5C);
    check("R10 dev_wr", {7'b0, s_dwr}, 8'h01);
    check("R10 dev_idx", s_didx, 8'h31);
    check("R10 dev_wdata", s_dwdata, 8'h5C);
    bus_op(OP_DR, 8'h00);
    check("R10 dev_rd", {7'b0, s_drd}, 8'h01);
    check("R10 rdata", s_rdata, 8'h31 ^ 8'h3C);

    // R10: other device selected, no strobes
    bus_op(OP_IW, 8'h07);
    bus_op(OP_DW, 8'h02);
    bus_op(OP_IW, 8'h31);
    bus_op(OP_DW, 8'h77);
    check("R10 no dev_wr", {7'b0, s_dwr}, 8'h00);
    bus_op(OP_DR, 8'h00);
    check("R10 no dev_rd", {7'b0, s_drd}, 8'h00);
    check("R11 unmapped read", s_rdata, 8'hFF);
    // R9: activate bit held while another device is selected
    bus_op(OP_IW, 8'h30);
    bus_op(OP_DW, 8'h00);
    #2;
    check("R9 act held", {7'b0, dev_active}, 8'h01);

    // R4: lock key is not latched as index
    bus_op(OP_IW, 8'h20);
    bus_op(OP_IW, 8'hAA);
    bus_op(OP_IW, 8'h87);
    bus_op(OP_IW, 8'h87);
    bus_op(OP_IR, 8'h00);
    check("R4 index kept", s_rdata, 8'h20);

    // R1: reset in the middle of a run
    do_reset();
    #2;
    check("R1 act after reset", {7'b0, dev_active}, 8'h00);
    bus_op(OP_DR, 8'h00);
    check("R1 locked after reset", s_rdata, 8'hFF);
    bus_op(OP_IW, 8'h87);
    bus_op(OP_IW, 8'h87);
    bus_op(OP_IR, 8'h00);
    check("R1 index after reset", s_rdata, 8'h00);
    bus_op(OP_IW, 8'h07);
    bus_op(OP_DR, 8'h00);
    check("R1 ldn after reset", s_rdata, 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule